// File: doc/BRIEF.md
# Multi-Byte NFA String Matcher

This block scans packet payload for a small fixed set of byte strings, all of them in parallel. It is a one-hot nondeterministic automaton: each partial-match state is its own flip-flop, and each transition is AND-OR logic on earlier states and on byte compares against the pattern constants. The payload arrives `LANES` bytes per clock (1, 2 or 4), lane 0 holding the earliest byte. The word that carries the first payload byte in lane 0 is marked by `inSop`. The last word is marked by `inEop`, with `inEndCnt` giving how many of its lanes hold payload.

The state word is unrolled across the lanes inside one cycle. A pattern that ends in any lane is found, including one whose bytes are split across two or more words. A pattern may start at any byte offset. Patterns that begin with the same bytes share the flip-flops for that common prefix. An optional truncation parameter shortens every pattern to its first `TRUNC_LEN` bytes before the automaton is built.

Hits gather in a sticky per-packet vector. A classification stage supplies a per-packet enable mask, which is taken with the first word. The masked vector appears on `matchVec` together with a one-cycle `matchStrobe` in the cycle after the end-of-packet word.

Top module: `nfaStringMatcher`

## Requirements
- R1: Every pattern is searched at once over the same payload, starting at any byte offset. Bit p of `matchVec` is 1 when pattern p (bytes taken in order from pattern byte 0 onward) occurs anywhere in the packet payload.
- R2: A pattern whose bytes are split across consecutive words, or that ends in any lane 0..LANES-1, is detected.
- R3: Match bits are sticky within a packet. A hit early in the packet is still reported after any number of later words.
- R4: `matchStrobe` is high for exactly one cycle, the cycle after an accepted end-of-packet word, and `matchVec` changes only together with it.
- R5: The enable mask on `inEnable` is sampled with the start-of-packet word and ANDs the result. Its value on later words of the packet has no effect.
- R6: In the end-of-packet word, only lanes 0..inEndCnt-1 carry payload. Bytes in higher lanes never advance any state. A packet sent as a single word with `inEndCnt` = 0 reports all zeros.
- R7: With `TRUNC_LEN` > 0, each pattern longer than `TRUNC_LEN` is matched on its first `TRUNC_LEN` bytes only.
- R8: No match spans two packets. All partial-match state is dropped at start of packet.
- R9: Cycles with `inValid` low inside a packet leave the partial-match state unchanged. Valid words outside a packet (with no start mark) are ignored, and their end marks produce no strobe.
- R10: After reset, `matchVec` is all zeros and `matchStrobe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Payload word valid |
| inSop | input | 1 | Word holds the first payload byte in lane 0 |
| inEop | input | 1 | Last word of the packet |
| inEndCnt | input | $clog2(LANES+1) | Number of payload lanes in the last word |
| inBytes | input | 8*LANES | Payload bytes, lane j at bits 8j+7..8j |
| inEnable | input | NUM_PAT | Per-pattern enable from classification, sampled at start of packet |
| matchVec | output | NUM_PAT | Masked per-packet match result |
| matchStrobe | output | 1 | One-cycle pulse when `matchVec` is updated |

## Verification
The checker assumes that `inEndCnt` never exceeds `LANES` on an end word. It also assumes that a start mark arrives only with valid data, and that masks and results are judged against the mask in force at the start word. The bench keeps to this: each packet's word count and end count are derived from its byte length. It puts random, sometimes deliberately misleading bytes into lanes past the end and into idle cycles. It changes `inEnable` on every word after the start word. A second instance with truncation runs on the same stream, so each packet is checked against a plain substring search for both pattern lengths.

// File: rtl/nfaMatchPkg.sv
package nfaMatchPkg;
  localparam int MAX_LANES = 4;

  typedef struct packed {
    logic                 startPkt;
    logic                 endPkt;
    logic [MAX_LANES-1:0] laneEn;
  } ctrlStb_t;
endpackage

// File: rtl/nfaMatchCtrl.sv
module nfaMatchCtrl
  import nfaMatchPkg::*;
#(
  parameter int LANES = 4,
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          inValid,
  input  logic          inSop,
  input  logic          inEop,
  input  logic [CW-1:0] inEndCnt,
  output ctrlStb_t      stb,
  output logic          reportStb
);
  logic inPkt;
  logic active;
  logic [CW-1:0] laneCnt;

  assign active  = inValid && (inSop || inPkt);
  assign laneCnt = inEop ? inEndCnt : CW'(LANES);

  always_comb begin
    stb          = '0;
    stb.startPkt = inValid && inSop;
    stb.endPkt   = active && inEop;
    for (int j = 0; j < LANES; j++) begin
      stb.laneEn[j] = active && (CW'(j) < laneCnt);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inPkt     <= 1'b0;
      reportStb <= 1'b0;
    end else begin
      reportStb <= stb.endPkt;
      if (stb.startPkt && !inEop) inPkt <= 1'b1;
      else if (stb.endPkt)        inPkt <= 1'b0;
    end
  end
endmodule

// File: rtl/nfaMatchDatapath.sv
module nfaMatchDatapath
  import nfaMatchPkg::*;
#(
  parameter int NUM_PAT   = 4,
  parameter int MAX_LEN   = 3,
  parameter int LANES     = 4,
  parameter int TRUNC_LEN = 0,
  parameter logic [NUM_PAT-1:0][MAX_LEN-1:0][7:0] PATTERNS = '0,
  parameter logic [NUM_PAT-1:0][7:0] PAT_LEN = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlStb_t             stb,
  input  logic [8*LANES-1:0]   inBytes,
  input  logic [NUM_PAT-1:0]   inEnable,
  output logic [NUM_PAT-1:0]   matchVec
);
  function automatic int effLen(int p);
    int l = int'(PAT_LEN[p]);
    if (TRUNC_LEN > 0 && TRUNC_LEN < l) l = TRUNC_LEN;
    return l;
  endfunction

  // lowest-numbered pattern owning the same prefix state (shared flop)
  function automatic int ownerOf(int p, int k);
    for (int q = 0; q <= p; q++) begin
      if (k < effLen(q) - 1) begin
        logic same = 1'b1;
        for (int i = 0; i <= k; i++)
          if (PATTERNS[q][i] != PATTERNS[p][i]) same = 1'b0;
        if (same) return q;
      end
    end
    return p;
  endfunction

  logic st  [NUM_PAT][MAX_LEN];
  logic act [LANES+1][NUM_PAT][MAX_LEN];
  logic [NUM_PAT-1:0] laneHit [LANES];
  logic [NUM_PAT-1:0] hitNow, sticky, stickyNext, maskReg, effMask;

  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    for (genvar k = 0; k < MAX_LEN; k++) begin : g_pos
      if (k < effLen(p) - 1) begin : g_live
        if (ownerOf(p, k) == p) begin : g_own
          always_ff @(posedge clk) begin
            if (!rstN) st[p][k] <= 1'b0;
            else       st[p][k] <= act[LANES][p][k];
          end
        end else begin : g_shared
          assign st[p][k] = st[ownerOf(p, k)][k];
        end
      end else begin : g_none
        assign st[p][k] = 1'b0;
      end
      assign act[0][p][k] = stb.startPkt ? 1'b0 : st[p][k];
      for (genvar j = 0; j < LANES; j++) begin : g_lane
        logic prev;
        if (k == 0) begin : g_first
          assign prev = 1'b1;
        end else begin : g_next
          assign prev = act[j][p][k-1];
        end
        if (k < effLen(p)) begin : g_step
          assign act[j+1][p][k] = stb.laneEn[j]
            ? (prev && inBytes[8*j +: 8] == PATTERNS[p][k]) : act[j][p][k];
        end else begin : g_off
          assign act[j+1][p][k] = 1'b0;
        end
      end
    end
    for (genvar j = 0; j < LANES; j++) begin : g_hit
      assign laneHit[j][p] = stb.laneEn[j] && act[j+1][p][effLen(p)-1];
    end
  end

  always_comb begin
    hitNow = '0;
    for (int j = 0; j < LANES; j++) hitNow |= laneHit[j];
  end

  assign stickyNext = (stb.startPkt ? '0 : sticky) | hitNow;
  assign effMask    = stb.startPkt ? inEnable : maskReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sticky   <= '0;
      maskReg  <= '0;
      matchVec <= '0;
    end else begin
      sticky  <= stickyNext;
      maskReg <= effMask;
      if (stb.endPkt) matchVec <= stickyNext & effMask;
    end
  end
endmodule

// File: rtl/nfaStringMatcher.sv
module nfaStringMatcher
  import nfaMatchPkg::*;
#(
  parameter int NUM_PAT   = 4,
  parameter int MAX_LEN   = 3,
  parameter int LANES     = 4,
  parameter int TRUNC_LEN = 0,
  parameter logic [NUM_PAT-1:0][MAX_LEN-1:0][7:0] PATTERNS =
    {{8'h61, 8'h61, 8'h61},   // pattern 3: "aaa"
     {8'h00, 8'h61, 8'h62},   // pattern 2: "ba"
     {8'h64, 8'h62, 8'h61},   // pattern 1: "abd"
     {8'h63, 8'h62, 8'h61}},  // pattern 0: "abc"
  parameter logic [NUM_PAT-1:0][7:0] PAT_LEN = {8'd3, 8'd2, 8'd3, 8'd3},
  localparam int CW = $clog2(LANES + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 inValid,
  input  logic                 inSop,
  input  logic                 inEop,
  input  logic [CW-1:0]        inEndCnt,
  input  logic [8*LANES-1:0]   inBytes,
  input  logic [NUM_PAT-1:0]   inEnable,
  output logic [NUM_PAT-1:0]   matchVec,
  output logic                 matchStrobe
);
  ctrlStb_t stb;

  initial begin
    if (LANES < 1 || LANES > MAX_LANES) $error("LANES out of range");
  end

  nfaMatchCtrl #(.LANES(LANES)) u_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop),
    .inEop(inEop), .inEndCnt(inEndCnt), .stb(stb), .reportStb(matchStrobe)
  );

  nfaMatchDatapath #(
    .NUM_PAT(NUM_PAT), .MAX_LEN(MAX_LEN), .LANES(LANES),
    .TRUNC_LEN(TRUNC_LEN), .PATTERNS(PATTERNS), .PAT_LEN(PAT_LEN)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .inBytes(inBytes),
    .inEnable(inEnable), .matchVec(matchVec)
  );
endmodule

// File: rtl/nfaMatchChecker.sv
module nfaMatchChecker #(
  parameter int NUM_PAT = 4,
  parameter int LANES   = 4,
  localparam int CW = $clog2(LANES + 1)
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               inSop,
  input logic               inEop,
  input logic [CW-1:0]      inEndCnt,
  input logic [NUM_PAT-1:0] inEnable,
  input logic [NUM_PAT-1:0] matchVec,
  input logic               matchStrobe
);
  logic [NUM_PAT-1:0] heldMask, curMask;
  assign curMask = (inValid && inSop) ? inEnable : heldMask;
  always_ff @(posedge clk) begin
    if (!rstN) heldMask <= '0;
    else       heldMask <= curMask;
  end

  p_strobe_after_eop_r4: assert property (@(posedge clk) disable iff (!rstN)
    matchStrobe |-> $past(inValid && inEop));

  p_vec_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    !matchStrobe |-> $stable(matchVec));

  p_masked_r5: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inEop) |=> (!matchStrobe || (matchVec & ~$past(curMask)) == '0));

  p_empty_pkt_r6: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inSop && inEop && inEndCnt == '0) |=> (matchStrobe && matchVec == '0));

  p_reset_r10: assert property (@(posedge clk)
    !rstN |=> (!matchStrobe && matchVec == '0));
endmodule

bind nfaStringMatcher nfaMatchChecker #(.NUM_PAT(NUM_PAT), .LANES(LANES)) u_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
  .inEndCnt(inEndCnt), .inEnable(inEnable), .matchVec(matchVec),
  .matchStrobe(matchStrobe)
);

// File: tb/nfaStringMatcher_bench.sv
module nfaStringMatcher_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 4;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0, inSop = 1'b0, inEop = 1'b0;
  logic [2:0] inEndCnt = '0;
  logic [8*LANES-1:0] inBytes = '0;
  logic [NP-1:0] inEnable = '0;
  logic [NP-1:0] vecFull, vecShort;
  logic stbFull, stbShort;

  int checks = 0, errors = 0, cycles = 0;
  int strobesSeen = 0, eopsSent = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [7:0] pkt [64];
  int pktLen = 0;
  bit forceBubble = 0;
  logic [7:0] fillByte = 8'h63;
  bit useFill = 0;
  string pats [NP] = '{"abc", "abd", "ba", "aaa"};

  always #(CLK_PERIOD/2) clk = ~clk;

  nfaStringMatcher u_nfaStringMatcher (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inEndCnt(inEndCnt), .inBytes(inBytes), .inEnable(inEnable),
    .matchVec(vecFull), .matchStrobe(stbFull));

  nfaStringMatcher #(.TRUNC_LEN(2)) u_nfaStringMatcherShort (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inEop(inEop),
    .inEndCnt(inEndCnt), .inBytes(inBytes), .inEnable(inEnable),
    .matchVec(vecShort), .matchStrobe(stbShort));

  function automatic logic [31:0] nextRng(logic [31:0] x);
    x ^= x << 13; x ^= x >> 17; x ^= x << 5;
    return x;
  endfunction

  function automatic logic [7:0] randLetter();
    rng = nextRng(rng);
    return 8'h61 + 8'(rng[1:0]);
  endfunction

  function automatic logic [NP-1:0] refMatch(int trunc, logic [NP-1:0] en);
    logic [NP-1:0] r = '0;
    for (int p = 0; p < NP; p++) begin
      int l = pats[p].len();
      if (trunc > 0 && trunc < l) l = trunc;
      for (int i = 0; i + l <= pktLen; i++) begin
        bit ok = 1;
        for (int k = 0; k < l; k++) if (pkt[i+k] != pats[p][k]) ok = 0;
        if (ok) r[p] = 1'b1;
      end
    end
    return r & en;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic setPkt(string s);
    pktLen = s.len();
    for (int i = 0; i < pktLen; i++) pkt[i] = s[i];
  endtask

  task automatic idleCycle(logic v, logic e);
    inValid = v; inSop = 1'b0; inEop = e; inEndCnt = 3'd4;
    for (int j = 0; j < LANES; j++) inBytes[8*j +: 8] = useFill ? fillByte : randLetter();
    @(negedge clk);
  endtask

  task automatic sendPkt(string tag, logic [NP-1:0] en);
    int words = (pktLen == 0) ? 1 : (pktLen + LANES - 1) / LANES;
    for (int w = 0; w < words; w++) begin
      inValid = 1'b1;
      inSop = (w == 0);
      inEop = (w == words - 1);
      inEndCnt = inEop ? 3'(pktLen - LANES * w) : 3'd0;
      inEnable = (w == 0) ? en : ~en;
      for (int j = 0; j < LANES; j++) begin
        int idx = LANES * w + j;
        inBytes[8*j +: 8] = (idx < pktLen) ? pkt[idx] : (useFill ? fillByte : randLetter());
      end
      @(negedge clk);
      if (w != words - 1) begin
        rng = nextRng(rng);
        if (forceBubble || rng[3:0] == 4'd0) idleCycle(1'b0, 1'b0);
      end
    end
    eopsSent++;
    inValid = 1'b0; inSop = 1'b0; inEop = 1'b0; inEnable = ~en;
    check({tag, " strobe R4"}, 32'(stbFull), 32'd1);
    check({tag, " full"}, 32'(vecFull), 32'(refMatch(0, en)));
    check({tag, " short R7"}, 32'(vecShort), 32'(refMatch(2, en)));
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rstN && stbFull) strobesSeen++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset vec", 32'(vecFull), 32'd0);
    check("R10 reset strobe", 32'(stbFull), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    setPkt("xxxabczz"); sendPkt("R2 straddle", 4'hF);
    setPkt("zabd");     sendPkt("R2 lane3 end", 4'hF);
    setPkt("abcxxxxxxxxxxxxxx"); sendPkt("R3 sticky", 4'hF);
    setPkt("abcaaaba"); sendPkt("R5 mask", 4'b0001);
    setPkt("abcaaaba"); sendPkt("R5 mask2", 4'b1010);
    useFill = 1; fillByte = 8'h63;
    setPkt("ab");       sendPkt("R6 tail", 4'hF);
    setPkt("");         sendPkt("R6 empty", 4'hF);
    setPkt("xxab");     sendPkt("R8 first", 4'hF);
    setPkt("cxxx");     sendPkt("R8 second", 4'hF);
    forceBubble = 1;
    setPkt("xxabdxxx"); sendPkt("R9 bubble", 4'hF);
    setPkt("xxxbaxxa"); sendPkt("R9 bubble2", 4'hF);
    forceBubble = 0;
    idleCycle(1'b1, 1'b1);
    idleCycle(1'b1, 1'b1);
    check("R9 stray eop strobe", 32'(stbFull), 32'd0);
    setPkt("xaxyz");    sendPkt("R9 after stray", 4'hF);
    useFill = 0;

    for (int n = 0; n < 400; n++) begin
      rng = nextRng(rng);
      pktLen = int'(rng[4:0] % 21);
      for (int i = 0; i < pktLen; i++) pkt[i] = randLetter();
      rng = nextRng(rng);
      sendPkt("R1 sweep", rng[7] ? 4'hF : rng[3:0]);
      if (rng[9]) idleCycle(1'b0, 1'b0);
    end

    repeat (2) @(negedge clk);
    check("R4 strobe count", 32'(strobesSeen), 32'(eopsSent));
    finishRun();
  end
endmodule